// File: doc/BRIEF.md
# Indexed Address Page-Fixup Sequencer

This block produces the address-bus activity of an 8-bit processor's absolute indexed addressing mode. A caller asserts a start request together with an operation class, a base address (low and high bytes) and an index value. The block registers the operands and steps through a fixed list of cycles. It places the base address on the bus, adds the index to the base low byte, and then presents the indexed address. A high-byte fixup cycle may follow.

For read-class operations, the fixup cycle is inserted only when the low-byte addition carried. Without a carry, the indexed address in the third address cycle is already the final operand address. Write and read-modify-write operations always take the fixup cycle. In that cycle the incremented high byte is always computed, but it reaches the bus only if the stored carry flag is set. The carry is held in a flag register at the end of the addition cycle. The fixup decision therefore does not depend on the live adder carry, which is overwritten by the high-byte increment.

The block reports progress on a cycle-state output. It raises a one-cycle done pulse in the cycle that carries the final effective address.

Top module: `idxFixupSeq`

## Requirements
- R1: A synchronous active-high reset, applied in any cycle, forces on the following clock edge cycleState = 0 (idle), done = 0, addrBus = 0 and the carry flag cleared.
- R2: A start request sampled while idle begins a sequence. cycleState then reads 1, 2, 3, 4 on the next four clock edges, and 5 when a fixup cycle is taken. addrBus is 0 in cycle 1 and equals {baseHi, baseLo} in cycles 2 and 3.
- R3: In cycle 4, addrBus equals {baseHi, (baseLo + index) mod 256}.
- R4: opClass 2'b00 selects a read. A read whose low-byte sum does not exceed 255 raises done in cycle 4 and returns to idle on the next edge, for 4 cycles in total.
- R5: A read whose low-byte sum exceeds 255 enters cycle 5 with addrBus = {(baseHi + 1) mod 256, sumLo}, raises done there and not in cycle 4.
- R6: opClass 2'b01 (write), 2'b10 (read-modify-write) and 2'b11 (handled as write) always enter cycle 5. done is raised only in cycle 5. The bus high byte there is baseHi + 1 after a carry and baseHi otherwise.
- R7: The bus low byte in cycle 5 equals its value in cycle 4.
- R8: done is high for exactly one cycle per sequence.
- R9: During a sequence, start requests and changes to opClass, baseLo, baseHi and index have no effect on cycleState, done or addrBus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| opClass | input | 2 | 00 read, 01 write, 10 read-modify-write, 11 as write |
| baseLo | input | 8 | Base address low byte |
| baseHi | input | 8 | Base address high byte |
| index | input | 8 | Index register value |
| addrBus | output | 16 | Address presented this cycle |
| cycleState | output | 3 | 0 idle, 1 to 5 sequence cycle |
| done | output | 1 | Final effective address is on the bus |

## Verification
A start applied before edge k yields cycle n of the sequence on the outputs after edge k+n. The bench drives inputs on the falling edge and samples at each following falling edge, comparing cycleState, addrBus and done to values computed from the operands. The idle state is checked one edge after the last sequence cycle. The reset result is checked one edge after reset is raised, which is also done during a sequence. The stimulus that R9 says must be ignored is applied in cycle 2, and its absence of effect is checked in every later cycle of the same sequence.

// File: rtl/idx_fixup_pkg.sv
package idx_fixup_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_C1   = 3'd1,
    S_C2   = 3'd2,
    S_C3   = 3'd3,
    S_C4   = 3'd4,
    S_C5   = 3'd5
  } seqStateT;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_ALT   = 2'b11
  } opClassT;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands
    logic addLo;    // low byte + index, capture carry
    logic addHi;    // high byte + 1 (always computed)
    logic selBase;  // bus = base address
    logic selIdx;   // bus = {hi, sumLo}
    logic selFix;   // bus = {gated hi, sumLo}
  } ctrlT;

endpackage

// File: rtl/idx_fix_ctrl.sv
module idx_fix_ctrl
  import idx_fixup_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] opClass,
  input  logic       carryFlag,
  output ctrlT       ctrl,
  output logic [2:0] cycleState,
  output logic       done
);

  seqStateT state, stateNext;
  logic     isRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      isRead <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) isRead <= (opClass == OP_READ);
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  stateNext = start ? S_C1 : S_IDLE;
      S_C1:    stateNext = S_C2;
      S_C2:    stateNext = S_C3;
      S_C3:    stateNext = S_C4;
      S_C4:    stateNext = (isRead && !carryFlag) ? S_IDLE : S_C5;
      S_C5:    stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    ctrl         = '0;
    ctrl.load    = (state == S_IDLE) && start;
    ctrl.addLo   = (state == S_C3);
    ctrl.addHi   = (state == S_C4);
    ctrl.selBase = (state == S_C2) || (state == S_C3);
    ctrl.selIdx  = (state == S_C4);
    ctrl.selFix  = (state == S_C5);
  end

  assign cycleState = state;
  assign done = ((state == S_C4) && isRead && !carryFlag) || (state == S_C5);

  // R8: done never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: fixed walk through the early cycles
  a_r2_walk: assert property (@(posedge clk) disable iff (rst)
    (state == S_C2) |=> (state == S_C3));

  // R4: read without stored carry finishes from cycle 4
  a_r4_read_skip: assert property (@(posedge clk) disable iff (rst)
    (state == S_C4 && isRead && !carryFlag) |=> (state == S_IDLE));

  // R6: writes and read-modify-writes always take the fixup cycle
  a_r6_always_fix: assert property (@(posedge clk) disable iff (rst)
    (state == S_C4 && !isRead) |=> (state == S_C5));

  // R9: a sequence never restarts part way through
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |=> (state != S_C1));

endmodule

// File: rtl/idx_fix_dp.sv
module idx_fix_dp
  import idx_fixup_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BYTE_W = ADDR_W / 2
)(
  input  logic              clk,
  input  logic              rst,
  input  ctrlT              ctrl,
  input  logic [BYTE_W-1:0] baseLo,
  input  logic [BYTE_W-1:0] baseHi,
  input  logic [BYTE_W-1:0] index,
  output logic              carryFlag,
  output logic [ADDR_W-1:0] addrBus
);

  logic [BYTE_W-1:0] opLo, opHi, idxReg, sumLo, hiInc;
  logic [BYTE_W-1:0] aluA, aluB, aluSum, busHi;
  logic              aluCin, aluCout;

  // one shared adder: low byte + index, then high byte + 1
  always_comb begin
    aluA   = ctrl.addLo ? opLo : opHi;
    aluB   = ctrl.addLo ? idxReg : '0;
    aluCin = ctrl.addHi;
    {aluCout, aluSum} = {1'b0, aluA} + {1'b0, aluB} + {{BYTE_W{1'b0}}, aluCin};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opLo      <= '0;
      opHi      <= '0;
      idxReg    <= '0;
      sumLo     <= '0;
      hiInc     <= '0;
      carryFlag <= 1'b0;
    end else begin
      if (ctrl.load) begin
        opLo   <= baseLo;
        opHi   <= baseHi;
        idxReg <= index;
      end
      if (ctrl.addLo) begin
        sumLo     <= aluSum;
        carryFlag <= aluCout;   // held; live carry is reused next cycle
      end
      if (ctrl.addHi) hiInc <= aluSum;
    end
  end

  // incremented high byte reaches the bus only after a stored carry
  assign busHi = carryFlag ? hiInc : opHi;

  always_comb begin
    addrBus = '0;
    if (ctrl.selBase)     addrBus = {opHi, opLo};
    else if (ctrl.selIdx) addrBus = {opHi, sumLo};
    else if (ctrl.selFix) addrBus = {busHi, sumLo};
  end

  // R7: low byte carried unchanged into the fixup cycle
  a_r7_low_hold: assert property (@(posedge clk) disable iff (rst)
    ctrl.selFix |-> addrBus[BYTE_W-1:0] == $past(addrBus[BYTE_W-1:0]));

  // R5: high byte steps by exactly the stored carry across the fixup
  a_r5_hi_step: assert property (@(posedge clk) disable iff (rst)
    ctrl.selFix |-> (BYTE_W'(addrBus[ADDR_W-1:BYTE_W] - $past(addrBus[ADDR_W-1:BYTE_W]))
                     == BYTE_W'(carryFlag)));

  // R9: operands frozen outside the load strobe
  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(opLo) && $stable(opHi) && $stable(idxReg)));

endmodule

// File: rtl/idxFixupSeq.sv
module idxFixupSeq
  import idx_fixup_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int BYTE_W = ADDR_W / 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        opClass,
  input  logic [BYTE_W-1:0] baseLo,
  input  logic [BYTE_W-1:0] baseHi,
  input  logic [BYTE_W-1:0] index,
  output logic [ADDR_W-1:0] addrBus,
  output logic [2:0]        cycleState,
  output logic              done
);

  ctrlT ctrl;
  logic carryFlag;

  idx_fix_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .opClass    (opClass),
    .carryFlag  (carryFlag),
    .ctrl       (ctrl),
    .cycleState (cycleState),
    .done       (done)
  );

  idx_fix_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .baseLo    (baseLo),
    .baseHi    (baseHi),
    .index     (index),
    .carryFlag (carryFlag),
    .addrBus   (addrBus)
  );

endmodule

// File: tb/idxFixupSeq_test.sv
module idxFixupSeq_test;

  logic        clk = 1'b0;
  logic        rst, start;
  logic [1:0]  opClass;
  logic [7:0]  baseLo, baseHi, index;
  logic [15:0] addrBus;
  logic [2:0]  cycleState;
  logic        done;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  idxFixupSeq uut (
    .clk(clk), .rst(rst), .start(start), .opClass(opClass),
    .baseLo(baseLo), .baseHi(baseHi), .index(index),
    .addrBus(addrBus), .cycleState(cycleState), .done(done)
  );

  task automatic check(string req, string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expCycles(logic [1:0] c, logic [7:0] lo, logic [7:0] ix);
    bit cy = (int'(lo) + int'(ix)) > 255;
    return (c == 2'b00 && !cy) ? 4 : 5;
  endfunction

  function automatic logic [15:0] expBus(int cyc, logic [7:0] lo, logic [7:0] hi, logic [7:0] ix);
    bit cy = (int'(lo) + int'(ix)) > 255;
    logic [7:0] s = lo + ix;
    logic [7:0] h = cy ? hi + 8'd1 : hi;
    case (cyc)
      2, 3:    return {hi, lo};
      4:       return {hi, s};
      5:       return {h, s};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string reqOf(int cyc, logic [1:0] c);
    if (cyc <= 3) return "R2";
    if (cyc == 4) return "R3";
    return (c == 2'b00) ? "R5" : "R6";
  endfunction

  // one full sequence; disturb=1 applies ignored stimulus in cycle 2
  task automatic runSeq(logic [1:0] c, logic [7:0] lo, logic [7:0] hi, logic [7:0] ix, bit disturb);
    int n = expCycles(c, lo, ix);
    int doneCnt = 0;
    logic [7:0] prevLo = 8'h00;
    @(negedge clk);
    start = 1'b1; opClass = c; baseLo = lo; baseHi = hi; index = ix;
    for (int cyc = 1; cyc <= n; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      check(disturb && cyc > 2 ? "R9" : "R2", "cycleState", cycleState, cyc);
      check(disturb && cyc > 2 ? "R9" : reqOf(cyc, c), "addrBus", addrBus, expBus(cyc, lo, hi, ix));
      check(n == 4 ? "R4" : (c == 2'b00 ? "R5" : "R6"), "done", done, (cyc == n));
      if (cyc == 5) check("R7", "low byte", addrBus[7:0], prevLo);
      prevLo = addrBus[7:0];
      if (done) doneCnt++;
      if (disturb && cyc == 2) begin
        start = 1'b1; opClass = 2'(~c); baseLo = ~lo; baseHi = ~hi; index = ix + 8'd77;
      end else if (disturb && cyc == 3) begin
        start = 1'b0;
      end
    end
    @(negedge clk);
    check("R4", "idle after", cycleState, 0);
    check("R8", "done after", done, 0);
    check("R8", "done count", doneCnt, 1);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; opClass = 2'b00;
    baseLo = 8'h00; baseHi = 8'h00; index = 8'h00;
    void'($urandom(32'd4711));
    @(negedge clk); @(negedge clk);
    check("R1", "cycleState", cycleState, 0);
    check("R1", "done", done, 0);
    check("R1", "addrBus", addrBus, 0);
    rst = 1'b0;

    runSeq(2'b00, 8'h10, 8'h20, 8'h05, 0);   // R4 read, no carry
    runSeq(2'b00, 8'hFF, 8'h20, 8'h01, 0);   // R5 read, carry
    runSeq(2'b00, 8'h00, 8'h00, 8'h00, 0);   // R4 zero index
    runSeq(2'b00, 8'hF0, 8'hFF, 8'h20, 0);   // R5 high byte wraps
    runSeq(2'b01, 8'h10, 8'h33, 8'h05, 0);   // R6 write, no carry
    runSeq(2'b10, 8'hC0, 8'h33, 8'h80, 0);   // R6 rmw, carry
    runSeq(2'b11, 8'h01, 8'h44, 8'h02, 0);   // R6 code 11 as write
    runSeq(2'b00, 8'h12, 8'h34, 8'h01, 1);   // R9 read disturbed
    runSeq(2'b01, 8'hFE, 8'h34, 8'h03, 1);   // R9 write disturbed

    // R1: reset in the middle of a sequence
    @(negedge clk);
    start = 1'b1; opClass = 2'b01; baseLo = 8'hAA; baseHi = 8'hBB; index = 8'h99;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1", "mid cycleState", cycleState, 0);
    check("R1", "mid done", done, 0);
    check("R1", "mid addrBus", addrBus, 0);
    rst = 1'b0;
    // carry flag cleared: a non-carrying read finishes in 4 cycles
    runSeq(2'b00, 8'h01, 8'h02, 8'h03, 0);

    for (int i = 0; i < 60; i++) begin
      runSeq(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule